// File: doc/BRIEF.md
# Packing DMA Address Sequencer

This block is a single-channel memory-to-memory DMA engine. It copies a block of operands from a source region to a destination region over a bus that is either 8 or 16 bits wide. When the two sides differ in operand size, it assembles two byte reads into one word write, or it splits one word read into two byte writes. A byte-wide device that sits on one half of a 16-bit bus uses only every second address. The sequencer therefore places the two bytes of a packed transfer 2 addresses apart and steps that pointer by 4 for each transfer.

Software provides the source and destination addresses, a byte count, the operand size of each side and the bus width, then pulses start. The engine requests the bus and waits for a grant. It then runs back-to-back read and write cycles at the full rate until the count is used up. It gives the bus back whenever another master asks for it, or when an interrupt is pending and the bus-clear option is enabled. After a new grant it continues with the first cycle it has not yet completed.

Top module: `dma_pack_seq`

## Requirements
- R1: With `cfg_bus16`=0, each transfer is one byte read at the source pointer followed by one byte write at the destination pointer, and both pointers step by 1, whatever the size bits are.
- R2: With a 16-bit bus and both sizes byte (`cfg_src_word`=0, `cfg_dst_word`=0), each transfer is one byte read and one byte write, and both pointers step by 1.
- R3: With a 16-bit bus, a byte source and a word destination, each transfer reads bytes at src and src+2, then writes one word at dst. The first byte read goes in bits 15:8 and the second in bits 7:0. Per transfer, src steps by 4 and dst by 2.
- R4: With a 16-bit bus, a word source and a byte destination, each transfer reads one word at src, writes bits 15:8 to dst and then writes bits 7:0 to dst+2. Per transfer, src steps by 2 and dst by 4.
- R5: With a 16-bit bus and both sizes word, each transfer is one word read and one word write, and both pointers step by 2.
- R6: The remaining count drops by 1 per transfer in the byte-to-byte case and by 2 otherwise, with a floor of zero. When it reaches zero, `busy` and `bus_req` fall and `done` rises. Start with a count of zero sets `done` without requesting the bus. Start clears `done`.
- R7: After start, `bus_req` rises, and no bus cycle begins until `bus_grant` is high. While granted and not preempted, cycles follow each other with no idle cycle in between.
- R8: When a bus cycle completes while `ext_breq` is high, or while both `irq_pend` and `bclr_en` are high, `mreq` is low on the next cycle. `bus_req` stays low while that condition holds. The block then resumes with the next pending cycle and repeats no completed cycle. `irq_pend` alone, with `bclr_en`=0, has no effect.
- R9: Once `mreq` is high, `maddr`, `mwrite`, `mword` and `mwdata` do not change until `mack` is sampled high.
- R10: Byte data travels on bits 7:0 of `mrdata` and `mwdata`, and a byte write drives bits 15:8 to zero. `mword`=1 marks a 16-bit cycle.
- R11: While reset is asserted and after its release, `bus_req`, `mreq`, `busy` and `done` are low.
- R12: A start pulse while `busy` is high is ignored, and the running block continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, taken only when idle |
| cfg_src | input | AW | Source start address |
| cfg_dst | input | AW | Destination start address |
| cfg_count | input | CW | Byte count |
| cfg_bus16 | input | 1 | 1: 16-bit bus, 0: 8-bit bus |
| cfg_src_word | input | 1 | Source operand size, 1 = word |
| cfg_dst_word | input | 1 | Destination operand size, 1 = word |
| bus_req | output | 1 | Bus ownership request |
| bus_grant | input | 1 | Bus ownership grant |
| ext_breq | input | 1 | Another master wants the bus |
| irq_pend | input | 1 | Interrupt pending |
| bclr_en | input | 1 | Allow a pending interrupt to release the bus |
| mreq | output | 1 | Bus cycle request |
| mwrite | output | 1 | 1 = write cycle |
| mword | output | 1 | 1 = 16-bit cycle |
| maddr | output | AW | Cycle address |
| mwdata | output | 16 | Write data |
| mrdata | input | 16 | Read data |
| mack | input | 1 | Cycle acknowledge |
| busy | output | 1 | Block transfer in progress |
| done | output | 1 | Last block finished |

## Verification
The bench tries every combination of bus width and the two size bits, each with counts from 1 to 5 and with 0 to 2 wait states. It records every bus cycle and compares the list with one computed from the increment rules, so a wrong step on either side, a swapped byte lane or a missing or extra cycle shows up. Odd counts in the 2-byte modes check that the count stops at zero. Further runs hold the grant back, preempt in the middle of a burst through the external request and through the interrupt path, with and without the enable, and pulse start while busy. These runs show whether the block releases the bus only when it should and resumes without repeating a cycle.

// File: rtl/dma_pack_pkg.sv
package dma_pack_pkg;
  typedef enum logic [1:0] {
    MODE_BB     = 2'd0,
    MODE_PACK   = 2'd1,
    MODE_UNPACK = 2'd2,
    MODE_WW     = 2'd3
  } xfer_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARB  = 2'd1,
    ST_CYC  = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic wr;
    logic word;
    logic off2;
    logic last;
  } step_op_t;
endpackage

// File: rtl/dma_mode_decode.sv
module dma_mode_decode
  import dma_pack_pkg::*;
(
  input  logic       bus16,
  input  logic       src_word,
  input  logic       dst_word,
  output xfer_mode_e mode,
  output logic [2:0] src_inc,
  output logic [2:0] dst_inc,
  output logic [1:0] bpt
);
  always_comb begin
    if (!bus16)                     mode = MODE_BB;
    else if (!src_word && !dst_word) mode = MODE_BB;
    else if (!src_word)             mode = MODE_PACK;
    else if (!dst_word)             mode = MODE_UNPACK;
    else                            mode = MODE_WW;
  end

  always_comb begin
    unique case (mode)
      MODE_BB:     begin src_inc = 3'd1; dst_inc = 3'd1; bpt = 2'd1; end
      MODE_PACK:   begin src_inc = 3'd4; dst_inc = 3'd2; bpt = 2'd2; end
      MODE_UNPACK: begin src_inc = 3'd2; dst_inc = 3'd4; bpt = 2'd2; end
      default:     begin src_inc = 3'd2; dst_inc = 3'd2; bpt = 2'd2; end
    endcase
  end
endmodule

// File: rtl/dma_step_plan.sv
module dma_step_plan
  import dma_pack_pkg::*;
(
  input  xfer_mode_e mode,
  input  logic [1:0] step,
  output step_op_t   op
);
  always_comb begin
    op = '0;
    unique case (mode)
      MODE_PACK: begin
        op.wr   = (step == 2'd2);
        op.word = (step == 2'd2);
        op.off2 = (step == 2'd1);
        op.last = (step == 2'd2);
      end
      MODE_UNPACK: begin
        op.wr   = (step != 2'd0);
        op.word = (step == 2'd0);
        op.off2 = (step == 2'd2);
        op.last = (step == 2'd2);
      end
      MODE_WW: begin
        op.wr   = (step == 2'd1);
        op.word = 1'b1;
        op.last = (step == 2'd1);
      end
      default: begin
        op.wr   = (step == 2'd1);
        op.last = (step == 2'd1);
      end
    endcase
  end
endmodule

// File: rtl/dma_ptr_unit.sv
module dma_ptr_unit #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] ld_src,
  input  logic [AW-1:0] ld_dst,
  input  logic [CW-1:0] ld_cnt,
  input  logic          adv,
  input  logic [2:0]    src_inc,
  input  logic [2:0]    dst_inc,
  input  logic [1:0]    bpt,
  output logic [AW-1:0] src_p,
  output logic [AW-1:0] dst_p,
  output logic          cnt_last
);
  logic [AW-1:0] src_q, src_d, dst_q, dst_d;
  logic [CW-1:0] cnt_q, cnt_d, bpt_ext;

  assign bpt_ext  = {{(CW-2){1'b0}}, bpt};
  assign cnt_last = (cnt_q <= bpt_ext);

  always_comb begin
    src_d = src_q;
    dst_d = dst_q;
    cnt_d = cnt_q;
    if (load) begin
      src_d = ld_src;
      dst_d = ld_dst;
      cnt_d = ld_cnt;
    end else if (adv) begin
      src_d = src_q + {{(AW-3){1'b0}}, src_inc};
      dst_d = dst_q + {{(AW-3){1'b0}}, dst_inc};
      cnt_d = cnt_last ? '0 : cnt_q - bpt_ext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
    end else if (load || adv) begin
      src_q <= src_d;
      dst_q <= dst_d;
      cnt_q <= cnt_d;
    end
  end

  assign src_p = src_q;
  assign dst_p = dst_q;

  assert_count_monotonic_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (cnt_q <= $past(cnt_q)));
endmodule

// File: rtl/dma_pack_seq.sv
module dma_pack_seq
  import dma_pack_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [CW-1:0] cfg_count,
  input  logic          cfg_bus16,
  input  logic          cfg_src_word,
  input  logic          cfg_dst_word,
  output logic          bus_req,
  input  logic          bus_grant,
  input  logic          ext_breq,
  input  logic          irq_pend,
  input  logic          bclr_en,
  output logic          mreq,
  output logic          mwrite,
  output logic          mword,
  output logic [AW-1:0] maddr,
  output logic [15:0]   mwdata,
  input  logic [15:0]   mrdata,
  input  logic          mack,
  output logic          busy,
  output logic          done
);
  logic [1:0] rst_sync;
  logic       rst_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int = rst_sync[1];

  seq_state_e state_q, state_d;
  logic [1:0] step_q, step_d;
  logic [15:0] hold_q, hold_d;
  logic       done_q, done_d;
  logic [2:0] szcfg_q, szcfg_d;
  logic       load, adv, preempt, cnt_last;
  xfer_mode_e mode;
  logic [2:0] src_inc, dst_inc;
  logic [1:0] bpt;
  step_op_t   op;
  logic [AW-1:0] src_p, dst_p, base;

  dma_mode_decode u_decode (
    .bus16(szcfg_q[2]), .src_word(szcfg_q[1]), .dst_word(szcfg_q[0]),
    .mode(mode), .src_inc(src_inc), .dst_inc(dst_inc), .bpt(bpt)
  );

  dma_step_plan u_plan (.mode(mode), .step(step_q), .op(op));

  dma_ptr_unit #(.AW(AW), .CW(CW)) u_ptr (
    .clk(clk), .rst_n(rst_int), .load(load),
    .ld_src(cfg_src), .ld_dst(cfg_dst), .ld_cnt(cfg_count),
    .adv(adv), .src_inc(src_inc), .dst_inc(dst_inc), .bpt(bpt),
    .src_p(src_p), .dst_p(dst_p), .cnt_last(cnt_last)
  );

  assign preempt = ext_breq | (irq_pend & bclr_en);

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    hold_d  = hold_q;
    done_d  = done_q;
    szcfg_d = szcfg_q;
    load    = 1'b0;
    adv     = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        load    = 1'b1;
        step_d  = 2'd0;
        szcfg_d = {cfg_bus16, cfg_src_word, cfg_dst_word};
        done_d  = (cfg_count == '0);
        state_d = (cfg_count == '0) ? ST_IDLE : ST_ARB;
      end
      ST_ARB: if (bus_grant && !preempt) state_d = ST_CYC;
      ST_CYC: if (mack) begin
        if (!op.wr) begin
          unique case (mode)
            MODE_BB:   hold_d = {hold_q[15:8], mrdata[7:0]};
            MODE_PACK: hold_d = (step_q == 2'd0) ? {mrdata[7:0], hold_q[7:0]}
                                                 : {hold_q[15:8], mrdata[7:0]};
            default:   hold_d = mrdata;
          endcase
        end
        if (op.last) begin
          adv    = 1'b1;
          step_d = 2'd0;
        end else begin
          step_d = step_q + 2'd1;
        end
        if (op.last && cnt_last) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else if (preempt) begin
          state_d = ST_ARB;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      state_q <= ST_IDLE;
      step_q  <= 2'd0;
      hold_q  <= '0;
      done_q  <= 1'b0;
      szcfg_q <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      hold_q  <= hold_d;
      done_q  <= done_d;
      szcfg_q <= szcfg_d;
    end
  end

  assign base    = op.wr ? dst_p : src_p;
  assign maddr   = base + {{(AW-2){1'b0}}, op.off2, 1'b0};
  assign mwrite  = op.wr;
  assign mword   = op.word;
  assign mreq    = (state_q == ST_CYC);
  assign bus_req = mreq | ((state_q == ST_ARB) & ~preempt);
  assign busy    = (state_q != ST_IDLE);
  assign done    = done_q;

  always_comb begin
    unique case (mode)
      MODE_BB:     mwdata = {8'h00, hold_q[7:0]};
      MODE_UNPACK: mwdata = (step_q == 2'd1) ? {8'h00, hold_q[15:8]} : {8'h00, hold_q[7:0]};
      default:     mwdata = hold_q;
    endcase
  end

  assert_hold_cycle_R9: assert property (@(posedge clk) disable iff (!rst_int)
    (mreq && !mack) |=> (mreq && $stable(maddr) && $stable(mwrite)
                         && $stable(mword) && $stable(mwdata)));

  assert_granted_R7: assert property (@(posedge clk) disable iff (!rst_int)
    mreq |-> bus_grant);

  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_int)
    (mreq && mack && preempt && !(op.last && cnt_last)) |=> !mreq);

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_int)
    done |-> (!busy && !bus_req));
endmodule

// File: tb/dma_pack_seq_bench.sv
module dma_pack_seq_bench;
  localparam int AW = 16;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] cfg_src = '0, cfg_dst = '0;
  logic [CW-1:0] cfg_count = '0;
  logic cfg_bus16 = 1'b0, cfg_src_word = 1'b0, cfg_dst_word = 1'b0;
  logic bus_req, bus_grant = 1'b0;
  logic ext_breq = 1'b0, irq_pend = 1'b0, bclr_en = 1'b0;
  logic mreq, mwrite, mword;
  logic [AW-1:0] maddr;
  logic [15:0] mwdata, mrdata = '0;
  logic mack = 1'b0;
  logic busy, done;

  int errors = 0, checks = 0, cycles = 0;
  int lat = 0, waitc = 0;
  logic grant_en = 1'b1;
  int pre_cnt = 0, r8_viol = 0, br_low_busy = 0;
  logic [AW-1:0] first_addr;
  logic first_wr, first_word, seen;
  logic [15:0] first_wd;

  logic [33:0] exp_e [64];
  logic [33:0] log_e [64];
  int exp_n = 0, log_n = 0;

  always #5 clk = ~clk;

  dma_pack_seq #(.AW(AW), .CW(CW)) u_dma_pack_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
    .cfg_count(cfg_count), .cfg_bus16(cfg_bus16), .cfg_src_word(cfg_src_word),
    .cfg_dst_word(cfg_dst_word), .bus_req(bus_req), .bus_grant(bus_grant),
    .ext_breq(ext_breq), .irq_pend(irq_pend), .bclr_en(bclr_en), .mreq(mreq),
    .mwrite(mwrite), .mword(mword), .maddr(maddr), .mwdata(mwdata), .mrdata(mrdata),
    .mack(mack), .busy(busy), .done(done)
  );

  function automatic logic [15:0] fdat(input logic [15:0] a);
    logic [15:0] t;
    t = a * 16'h0107;
    return t + 16'h0035;
  endfunction

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [33:0] act, input logic [33:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // grant model: grant follows request one cycle later
  initial forever begin
    @(negedge clk);
    bus_grant = bus_req & grant_en;
    cycles++;
    if (ext_breq) pre_cnt++; else pre_cnt = 0;
    if (busy && !bus_req) br_low_busy++;
  end

  // memory responder with programmable wait states
  initial forever begin
    @(negedge clk);
    if (mack) begin
      mack = 1'b0;
      waitc = 0;
      seen = 1'b0;
    end else if (mreq) begin
      if (!seen) begin
        seen = 1'b1;
        first_addr = maddr; first_wr = mwrite; first_word = mword; first_wd = mwdata;
      end
      if (waitc >= lat) begin
        chk(first_addr == maddr && first_wr == mwrite && first_word == mword &&
            first_wd == mwdata, "R9", "cycle fields changed before ack",
            {mwrite, mword, maddr, mwdata}, {first_wr, first_word, first_addr, first_wd});
        if (pre_cnt >= 5) r8_viol++;
        mrdata = mword ? fdat(maddr) : {8'h00, fdat(maddr) & 16'h00FF};
        if (log_n < 64) log_e[log_n] = {mwrite, mword, maddr, mwrite ? mwdata : 16'h0};
        log_n++;
        mack = 1'b1;
      end else begin
        waitc++;
      end
    end
  end

  initial begin
    seen = 1'b0;
    wait (cycles > 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=<150000", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic push(input logic [33:0] e);
    if (exp_n < 64) exp_e[exp_n] = e;
    exp_n++;
  endtask

  task automatic build_exp(input logic b16, input logic sw, input logic dw,
                           input logic [15:0] s, input logic [15:0] d, input int c);
    int bpt, ntr, si_inc, di_inc, m;
    logic [15:0] si, di, v0, v1;
    if (!b16 || (!sw && !dw)) m = 0; else if (!sw) m = 1; else if (!dw) m = 2; else m = 3;
    bpt = (m == 0) ? 1 : 2;
    si_inc = (m == 0) ? 1 : (m == 1) ? 4 : 2;
    di_inc = (m == 0) ? 1 : (m == 2) ? 4 : 2;
    ntr = (c + bpt - 1) / bpt;
    exp_n = 0;
    for (int i = 0; i < ntr; i++) begin
      si = s + 16'(i * si_inc);
      di = d + 16'(i * di_inc);
      v0 = fdat(si);
      v1 = fdat(si + 16'd2);
      case (m)
        0: begin push({2'b00, si, 16'h0}); push({2'b10, di, 8'h00, v0[7:0]}); end
        1: begin push({2'b00, si, 16'h0}); push({2'b00, si + 16'd2, 16'h0});
                 push({2'b11, di, v0[7:0], v1[7:0]}); end
        2: begin push({2'b01, si, 16'h0}); push({2'b10, di, 8'h00, v0[15:8]});
                 push({2'b10, di + 16'd2, 8'h00, v0[7:0]}); end
        default: begin push({2'b01, si, 16'h0}); push({2'b11, di, v0}); end
      endcase
    end
  endtask

  task automatic compare(input string req);
    chk(log_n == exp_n, req, "number of bus cycles", 34'(log_n), 34'(exp_n));
    for (int i = 0; i < exp_n && i < log_n && i < 64; i++)
      chk(log_e[i] == exp_e[i], req, $sformatf("cycle %0d {wr,word,addr,data} (R10)", i),
          log_e[i], exp_e[i]);
  endtask

  task automatic run(input logic b16, input logic sw, input logic dw,
                     input logic [15:0] s, input logic [15:0] d, input int c,
                     input int lat_i, input int hold_grant, input string req);
    int guard;
    build_exp(b16, sw, dw, s, d, c);
    log_n = 0; lat = lat_i;
    if (hold_grant > 0) grant_en = 1'b0;
    @(negedge clk);
    cfg_bus16 = b16; cfg_src_word = sw; cfg_dst_word = dw;
    cfg_src = s; cfg_dst = d; cfg_count = CW'(c); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R6", "done cleared by start", 34'(done), 34'(0));
    for (int k = 0; k < hold_grant; k++) begin
      chk(bus_req == 1'b1 && mreq == 1'b0, "R7", "request without grant",
          {32'h0, bus_req, mreq}, 34'b10);
      @(negedge clk);
    end
    grant_en = 1'b1;
    guard = 0;
    while (busy && guard < 3000) begin @(negedge clk); guard++; end
    chk(done && !busy && !bus_req && !mreq, "R6", "finished state",
        {30'h0, done, busy, bus_req, mreq}, 34'b1000);
    compare(req);
  endtask

  task automatic sweep_tag(input logic b16, input logic sw, input logic dw, output string t);
    if (!b16) t = "R1";
    else if (!sw && !dw) t = "R2";
    else if (!sw) t = "R3";
    else if (!dw) t = "R4";
    else t = "R5";
  endtask

  initial begin
    string tag;
    repeat (3) @(negedge clk);
    chk(!bus_req && !mreq && !busy && !done, "R11", "outputs during reset",
        {30'h0, bus_req, mreq, busy, done}, 34'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!bus_req && !mreq && !busy && !done, "R11", "outputs after reset",
        {30'h0, bus_req, mreq, busy, done}, 34'h0);

    for (int b = 0; b < 2; b++)
      for (int sz = 0; sz < 4; sz++)
        for (int c = 1; c <= 5; c++) begin
          sweep_tag(b[0], sz[1], sz[0], tag);
          run(b[0], sz[1], sz[0], 16'h0100 + 16'(c * 16 + sz),
              16'h0800 + 16'(c * 32 + b), c, (c + sz) % 3, 0, tag);
        end

    // zero count: done at once, no bus request (R6)
    log_n = 0;
    @(negedge clk);
    cfg_count = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done && !busy && !bus_req, "R6", "zero count completion",
        {31'h0, done, busy, bus_req}, 34'b100);
    @(negedge clk);
    chk(log_n == 0, "R6", "zero count made no cycle", 34'(log_n), 34'(0));

    // grant held back (R7)
    run(1'b1, 1'b0, 1'b1, 16'h0200, 16'h0900, 4, 0, 4, "R7");

    // external master preempts mid burst (R8)
    br_low_busy = 0; r8_viol = 0;
    fork
      run(1'b1, 1'b1, 1'b0, 16'h0300, 16'h0A00, 6, 1, 0, "R8");
      begin repeat (6) @(negedge clk); ext_breq = 1'b1; repeat (8) @(negedge clk); ext_breq = 1'b0; end
    join
    chk(br_low_busy > 0, "R8", "request dropped for external master", 34'(br_low_busy), 34'(1));
    chk(r8_viol == 0, "R8", "cycles while preempted", 34'(r8_viol), 34'(0));

    // interrupt pending without bus-clear enable: no effect (R8)
    br_low_busy = 0;
    irq_pend = 1'b1; bclr_en = 1'b0;
    run(1'b1, 1'b0, 1'b1, 16'h0400, 16'h0B00, 6, 0, 0, "R8");
    chk(br_low_busy == 0, "R8", "irq without enable kept bus", 34'(br_low_busy), 34'(0));
    irq_pend = 1'b0;

    // interrupt with bus-clear enable releases (R8)
    br_low_busy = 0;
    fork
      run(1'b1, 1'b1, 1'b1, 16'h0500, 16'h0C00, 6, 0, 0, "R8");
      begin repeat (5) @(negedge clk); bclr_en = 1'b1; irq_pend = 1'b1;
            repeat (6) @(negedge clk); irq_pend = 1'b0; bclr_en = 1'b0; end
    join
    chk(br_low_busy > 0, "R8", "irq with enable released bus", 34'(br_low_busy), 34'(1));

    // start while busy is ignored (R12)
    fork
      run(1'b0, 1'b1, 1'b1, 16'h0600, 16'h0D00, 5, 2, 0, "R12");
      begin repeat (4) @(negedge clk); cfg_src = 16'h7000; cfg_count = 16'd9;
            cfg_bus16 = 1'b1; start = 1'b1; @(negedge clk); start = 1'b0; end
    join

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule